// File: doc/BRIEF.md
# Three-Wire Mode Control Register

This block is the configuration front end of a stereo audio converter. A host shifts 8-bit command words into it over three wires: a data line, a shift clock and a latch line. The block decodes each word from its leading bits and updates one of three register groups. The first group holds the output attenuation code. The second holds the de-emphasis rate and enable, soft mute and double speed. The third holds the word-select polarity and the input framing format. Three separate writes are therefore needed to set every field.

A static select pin switches the block into a parallel fallback. In that mode two pins pick the de-emphasis rate and a low-active pin requests double speed. The remaining fields are forced to fixed values, and the serial registers keep their contents until serial mode comes back.

After reset the block also runs an internal power-on sequence. It counts rising edges of the word-select clock, and the serial port stays closed until the count completes. Every input is synchronised into the system clock domain with two flops before its edges are detected.

The serial deserialiser is a three-state machine:
- `DS_WAIT_POR`: ignores the port until the power-on count is done, then goes to `DS_COLLECT`.
- `DS_COLLECT`: shifts bits in. On a latch rising edge it goes to `DS_APPLY`, but only when at least 8 bits have arrived and serial mode is selected. Any other latch edge discards the partial word and stays in `DS_COLLECT`.
- `DS_APPLY`: issues a one-cycle command pulse and returns to `DS_COLLECT`.

Top module: `mode_ctl_port`

## Requirements
- R1: After reset in serial mode the outputs are: por_done 0, att_code 0, deem_rate 2'b11 (44.1 kHz), deem_en 0, mute_en 0, dbl_en 0, ws_pol 0 (word-select high means left) and fmt_i2s 0 (normal format).
- R2: por_done rises after POR_WS_CYCLES (64) rising edges of ws and then stays high. Serial words latched before it rises change nothing.
- R3: Data is sampled on each rising edge of cfg_sck, bit B0 first. A rising edge of cfg_ltch applies the last 8 bits shifted. A latch edge that follows fewer than 8 bits since the previous latch edge is ignored.
- R4: A word with B0=0 is an attenuation command. att_code takes B1..B7, with B1 as the MSB, so 7'h7F is full attenuation. The other fields are unchanged.
- R5: A word with B0..B2 = 1,0,0 sets deem_rate = {B3,B4} (00 off, 01 48 kHz, 10 32 kHz, 11 44.1 kHz), deem_en = B5, mute_en = B6 and dbl_en = B7. att_code and the format fields are unchanged.
- R6: A word with B0..B2 = 1,0,1 sets ws_pol = B6 and fmt_i2s = B7 (1 selects I2S). Every other field is unchanged.
- R7: A word whose B0..B1 are 1,1 matches no command and leaves every output unchanged.
- R8: With sel_serial low, the outputs come from the pins. deem_rate = {par_rate_a, par_rate_b}, so LL is off, HL is 32 kHz, LH is 48 kHz and HH is 44.1 kHz. deem_en = par_rate_a | par_rate_b and dbl_en = !par_dbl_n. att_code, mute_en, ws_pol and fmt_i2s are all 0.
- R9: Serial words latched while sel_serial is low are ignored. When serial mode returns, the outputs show the serial settings held before the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_serial | input | 1 | High selects the serial port, low selects the parallel pins |
| cfg_dat | input | 1 | Serial command data |
| cfg_sck | input | 1 | Serial shift clock; data is sampled on its rising edge |
| cfg_ltch | input | 1 | Latch; a rising edge applies the shifted word |
| ws | input | 1 | Word-select clock, counted for the power-on sequence |
| par_rate_a | input | 1 | Parallel de-emphasis rate select, first pin |
| par_rate_b | input | 1 | Parallel de-emphasis rate select, second pin |
| par_dbl_n | input | 1 | Parallel double-speed request, active low |
| por_done | output | 1 | Power-on sequence complete |
| att_code | output | 7 | Attenuation code |
| deem_rate | output | 2 | De-emphasis rate code |
| deem_en | output | 1 | De-emphasis enable |
| mute_en | output | 1 | Soft mute enable |
| dbl_en | output | 1 | Double-speed enable |
| ws_pol | output | 1 | Word-select polarity; 1 means high is right |
| fmt_i2s | output | 1 | Input framing; 1 selects I2S |

## Verification
The bench first sends a word before the power-on count ends. A design that opened the port too early would change att_code there, and one that counted a rising edge too many or too few would raise por_done in the wrong place. The bench then sends short words, and over-long words whose leading bits are junk. A design that applied a partial shift register, or took the first 8 bits instead of the last 8, would show a wrong field value. Undefined leading bits must leave all outputs alone, and a decoder that treated 1,1,x as a mode-1 or mode-2 word would corrupt them. The bench also writes a word during parallel mode and then returns to serial. A design that accepted that write, or cleared the serial registers on the switch, would fail the comparison made on every clock against the reference model.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int CMD_W   = 8;
    localparam int ATT_W   = CMD_W - 1;
    localparam int RATE_W  = 2;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_ATT   = 2'd1,
        CMD_MODE1 = 2'd2,
        CMD_MODE2 = 2'd3
    } cmd_kind_t;

    typedef enum logic [1:0] {
        DS_WAIT_POR = 2'd0,
        DS_COLLECT  = 2'd1,
        DS_APPLY    = 2'd2
    } ds_state_t;

    localparam logic [RATE_W-1:0] RATE_DEFAULT = 2'b11;
endpackage

// File: rtl/mcp_sync.sv
module mcp_sync #(
    parameter int          N       = 1,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    logic [N-1:0] stage1;
    logic [N-1:0] stage2;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[g] <= RST_VAL[g];
                stage2[g] <= RST_VAL[g];
            end else begin
                stage1[g] <= d_async[g];
                stage2[g] <= stage1[g];
            end
        end
    end

    assign d_sync = stage2;
endmodule

// File: rtl/mcp_por.sv
module mcp_por #(
    parameter int WS_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_s,
    output logic done
);
    localparam int CNT_W = $clog2(WS_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ws_prev;
    logic             ws_rise;

    assign ws_rise = ws_s && !ws_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ws_prev <= 1'b0;
            done    <= 1'b0;
        end else begin
            ws_prev <= ws_s;
            if (ws_rise && !done) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(WS_CYCLES - 1)) begin
                    done <= 1'b1;
                end
            end
        end
    end

    AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R2
endmodule

// File: rtl/mcp_deser.sv
module mcp_deser
    import mcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dat_s,
    input  logic             sck_s,
    input  logic             ltch_s,
    input  logic             accept_en,
    input  logic             por_done,
    output logic             cmd_valid,
    output cmd_kind_t        cmd_kind,
    output logic [CMD_W-1:0] cmd_word
);
    localparam int CNT_W = $clog2(CMD_W + 1);

    ds_state_t        state_q, state_d;
    logic [CMD_W-1:0] shreg_q;
    logic [CMD_W-1:0] word_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sck_prev, ltch_prev;
    logic             sck_rise, ltch_rise;
    logic             word_full;

    assign sck_rise  = sck_s && !sck_prev;
    assign ltch_rise = ltch_s && !ltch_prev;
    assign word_full = (cnt_q == CNT_W'(CMD_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_WAIT_POR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_WAIT_POR: if (por_done) state_d = DS_COLLECT;
            DS_COLLECT:  if (ltch_rise && accept_en && word_full) state_d = DS_APPLY;
            DS_APPLY:    state_d = DS_COLLECT;
            default:     state_d = DS_WAIT_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            word_q    <= '0;
            cnt_q     <= '0;
            sck_prev  <= 1'b0;
            ltch_prev <= 1'b0;
        end else begin
            sck_prev  <= sck_s;
            ltch_prev <= ltch_s;
            if (state_q == DS_WAIT_POR) begin
                cnt_q <= '0;
            end else if (ltch_rise) begin
                cnt_q <= '0;
                if (accept_en && word_full) word_q <= shreg_q;
            end else if (sck_rise) begin
                shreg_q <= {shreg_q[CMD_W-2:0], dat_s};
                if (!word_full) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        cmd_valid = (state_q == DS_APPLY);
        cmd_word  = word_q;
        if (!word_q[CMD_W-1])                     cmd_kind = CMD_ATT;
        else if (word_q[CMD_W-1 -: 3] == 3'b100)  cmd_kind = CMD_MODE1;
        else if (word_q[CMD_W-1 -: 3] == 3'b101)  cmd_kind = CMD_MODE2;
        else                                      cmd_kind = CMD_NONE;
    end

    AST_NO_CMD_BEFORE_POR: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> !cmd_valid); // R2
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R3
    AST_CMD_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> $past(ltch_rise)); // R3
endmodule

// File: rtl/mode_ctl_port.sv
module mode_ctl_port
    import mcp_pkg::*;
#(
    parameter int POR_WS_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_serial,
    input  logic              cfg_dat,
    input  logic              cfg_sck,
    input  logic              cfg_ltch,
    input  logic              ws,
    input  logic              par_rate_a,
    input  logic              par_rate_b,
    input  logic              par_dbl_n,
    output logic              por_done,
    output logic [ATT_W-1:0]  att_code,
    output logic [RATE_W-1:0] deem_rate,
    output logic              deem_en,
    output logic              mute_en,
    output logic              dbl_en,
    output logic              ws_pol,
    output logic              fmt_i2s
);
    localparam int NSYNC = 8;
    localparam logic [NSYNC-1:0] SYNC_RST = 8'b0001_0001;

    logic [NSYNC-1:0] raw, syn;
    logic serial_s, dat_s, sck_s, ltch_s, ws_s, ra_s, rb_s, dbln_s;

    assign raw = {ws, cfg_dat, cfg_sck, cfg_ltch, sel_serial, par_rate_a, par_rate_b, par_dbl_n};
    assign {ws_s, dat_s, sck_s, ltch_s, serial_s, ra_s, rb_s, dbln_s} = syn;

    mcp_sync #(.N(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw), .d_sync(syn)
    );

    mcp_por #(.WS_CYCLES(POR_WS_CYCLES)) u_por (
        .clk(clk), .rst_n(rst_n), .ws_s(ws_s), .done(por_done)
    );

    logic             cmd_valid;
    cmd_kind_t        cmd_kind;
    logic [CMD_W-1:0] cmd_word;

    mcp_deser u_deser (
        .clk(clk), .rst_n(rst_n), .dat_s(dat_s), .sck_s(sck_s), .ltch_s(ltch_s),
        .accept_en(serial_s), .por_done(por_done),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_word(cmd_word)
    );

    logic [ATT_W-1:0]  att_q;
    logic [RATE_W-1:0] rate_q;
    logic              den_q, mute_q, dbl_q, pol_q, fmt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q  <= '0;
            rate_q <= RATE_DEFAULT;
            den_q  <= 1'b0;
            mute_q <= 1'b0;
            dbl_q  <= 1'b0;
            pol_q  <= 1'b0;
            fmt_q  <= 1'b0;
        end else if (cmd_valid) begin
            unique case (cmd_kind)
                CMD_ATT:   att_q <= cmd_word[ATT_W-1:0];
                CMD_MODE1: begin
                    rate_q <= cmd_word[4:3];
                    den_q  <= cmd_word[2];
                    mute_q <= cmd_word[1];
                    dbl_q  <= cmd_word[0];
                end
                CMD_MODE2: begin
                    pol_q <= cmd_word[1];
                    fmt_q <= cmd_word[0];
                end
                CMD_NONE:  ;
                default:   ;
            endcase
        end
    end

    always_comb begin
        if (serial_s) begin
            att_code  = att_q;
            deem_rate = rate_q;
            deem_en   = den_q;
            mute_en   = mute_q;
            dbl_en    = dbl_q;
            ws_pol    = pol_q;
            fmt_i2s   = fmt_q;
        end else begin
            att_code  = '0;
            deem_rate = {ra_s, rb_s};
            deem_en   = ra_s | rb_s;
            mute_en   = 1'b0;
            dbl_en    = !dbln_s;
            ws_pol    = 1'b0;
            fmt_i2s   = 1'b0;
        end
    end

    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == CMD_NONE) |=>
        ($stable(att_q) && $stable(rate_q) && $stable(den_q) && $stable(mute_q)
         && $stable(dbl_q) && $stable(pol_q) && $stable(fmt_q))); // R7
    AST_ATT_ONLY_BY_ATT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != CMD_ATT) |=> $stable(att_q)); // R5
    AST_FMT_ONLY_BY_MODE2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != CMD_MODE2) |=> ($stable(fmt_q) && $stable(pol_q))); // R6
    AST_PAR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_s && $past(!serial_s)) |-> !cmd_valid); // R9
endmodule

// File: tb/mode_ctl_port_bench.sv
module mode_ctl_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_serial = 1'b1, cfg_dat = 1'b0, cfg_sck = 1'b0, cfg_ltch = 1'b0, ws = 1'b0;
    logic par_rate_a = 1'b0, par_rate_b = 1'b0, par_dbl_n = 1'b1;
    logic       por_done;
    logic [6:0] att_code;
    logic [1:0] deem_rate;
    logic       deem_en, mute_en, dbl_en, ws_pol, fmt_i2s;

    always #5 clk = ~clk;

    mode_ctl_port u_mode_ctl_port (
        .clk(clk), .rst_n(rst_n), .sel_serial(sel_serial), .cfg_dat(cfg_dat),
        .cfg_sck(cfg_sck), .cfg_ltch(cfg_ltch), .ws(ws), .par_rate_a(par_rate_a),
        .par_rate_b(par_rate_b), .par_dbl_n(par_dbl_n), .por_done(por_done),
        .att_code(att_code), .deem_rate(deem_rate), .deem_en(deem_en),
        .mute_en(mute_en), .dbl_en(dbl_en), .ws_pol(ws_pol), .fmt_i2s(fmt_i2s)
    );

    int total = 0;
    int bad = 0;
    bit chk_en = 0;
    bit finished = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_por = 0, m_att = 0, m_rate = 3, m_den = 0, m_mute = 0, m_dbl = 0, m_pol = 0, m_fmt = 0;
    int m_serial = 1;
    bit sent_q[$];

    function automatic logic [14:0] expected();
        int a, r, d, mu, db, p, f;
        if (m_serial != 0) begin
            a = m_att; r = m_rate; d = m_den; mu = m_mute; db = m_dbl; p = m_pol; f = m_fmt;
        end else begin
            a = 0; mu = 0; p = 0; f = 0;
            r = (par_rate_a ? 2 : 0) + (par_rate_b ? 1 : 0);
            d = (par_rate_a || par_rate_b) ? 1 : 0;
            db = par_dbl_n ? 0 : 1;
        end
        return {1'(m_por), 7'(a), 2'(r), 1'(d), 1'(mu), 1'(db), 1'(p), 1'(f)};
    endfunction

    function automatic logic [14:0] actual();
        return {por_done, att_code, deem_rate, deem_en, mute_en, dbl_en, ws_pol, fmt_i2s};
    endfunction

    always @(negedge clk) begin
        if (chk_en && !finished) begin
            total++;
            if (actual() !== expected()) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", cur_req, actual(), expected());
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_latch();
        bit b[8];
        int n;
        n = sent_q.size();
        if (n >= 8 && m_por != 0 && m_serial != 0) begin
            for (int i = 0; i < 8; i++) b[i] = sent_q[n - 8 + i];
            if (b[0] == 0) begin
                m_att = 0;
                for (int i = 1; i < 8; i++) m_att = m_att * 2 + b[i];
            end else if (b[1] == 0 && b[2] == 0) begin
                m_rate = b[3] * 2 + b[4];
                m_den = b[5]; m_mute = b[6]; m_dbl = b[7];
            end else if (b[1] == 0 && b[2] == 1) begin
                m_pol = b[6]; m_fmt = b[7];
            end
        end
        sent_q.delete();
    endtask

    // shift nbits of w, MSB of w (bit nbits-1) first, then latch
    task automatic send(input logic [15:0] w, input int nbits, input string req);
        chk_en = 0;
        cur_req = req;
        for (int i = nbits - 1; i >= 0; i--) begin
            cfg_dat = w[i];
            sent_q.push_back(w[i]);
            wclk(3);
            cfg_sck = 1'b1;
            wclk(3);
            cfg_sck = 1'b0;
            wclk(2);
        end
        cfg_ltch = 1'b1;
        wclk(3);
        cfg_ltch = 1'b0;
        wclk(8);
        model_latch();
        chk_en = 1;
        wclk(4);
    endtask

    task automatic ws_rises(input int n);
        for (int i = 0; i < n; i++) begin
            ws = 1'b1; wclk(4);
            ws = 1'b0; wclk(4);
        end
    endtask

    task automatic point_check(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_par(input bit a, input bit b, input bit dn, input string req);
        chk_en = 0;
        cur_req = req;
        par_rate_a = a; par_rate_b = b; par_dbl_n = dn;
        wclk(5);
        chk_en = 1;
        wclk(4);
        point_check(deem_rate == {a, b}, req, deem_rate, {a, b});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(4);
        // R1: defaults after reset
        cur_req = "R1";
        chk_en = 1;
        wclk(4);
        point_check(deem_rate == 2'b11 && !deem_en && !por_done, "R1", deem_rate, 3);

        // R2: word before power-on sequence is ignored
        send({8'h00, 8'h2A}, 8, "R2");
        point_check(att_code == 7'd0, "R2", att_code, 0);

        // R2: por_done after exactly 64 ws rising edges
        chk_en = 0;
        ws_rises(63);
        wclk(6);
        point_check(por_done == 1'b0, "R2", por_done, 0);
        ws_rises(1);
        wclk(6);
        m_por = 1;
        point_check(por_done == 1'b1, "R2", por_done, 1);
        chk_en = 1;
        cur_req = "R2";
        wclk(4);

        // R4: attenuation
        send({8'h00, 8'h55}, 8, "R4");
        point_check(att_code == 7'h55, "R4", att_code, 'h55);
        send({8'h00, 8'h7F}, 8, "R4");
        point_check(att_code == 7'h7F, "R4", att_code, 'h7F);

        // R5: mode 1
        send({8'h00, 8'b1000_1110}, 8, "R5");
        point_check(deem_rate == 2'b01 && deem_en && mute_en && !dbl_en && att_code == 7'h7F,
                    "R5", deem_rate, 1);
        send({8'h00, 8'b1001_0001}, 8, "R5");
        point_check(deem_rate == 2'b10 && !deem_en && !mute_en && dbl_en, "R5", deem_rate, 2);

        // R6: mode 2
        send({8'h00, 8'b1010_0011}, 8, "R6");
        point_check(ws_pol && fmt_i2s, "R6", {ws_pol, fmt_i2s}, 3);
        send({8'h00, 8'b1010_0001}, 8, "R6");
        point_check(!ws_pol && fmt_i2s && att_code == 7'h7F, "R6", {ws_pol, fmt_i2s}, 1);

        // R7: undefined leading bits
        send({8'h00, 8'b1100_0000}, 8, "R7");
        send({8'h00, 8'b1111_1111}, 8, "R7");
        point_check(att_code == 7'h7F && fmt_i2s && dbl_en, "R7", att_code, 'h7F);

        // R3: short word ignored, long word keeps the last eight bits
        send({11'h0, 5'b00000}, 5, "R3");
        point_check(att_code == 7'h7F, "R3", att_code, 'h7F);
        send({6'h0, 2'b11, 8'b0001_0010}, 10, "R3");
        point_check(att_code == 7'h12, "R3", att_code, 'h12);

        // R8: parallel pins
        chk_en = 0;
        sel_serial = 1'b0; m_serial = 0;
        set_par(1'b0, 1'b0, 1'b1, "R8");
        set_par(1'b1, 1'b0, 1'b1, "R8");
        set_par(1'b0, 1'b1, 1'b0, "R8");
        set_par(1'b1, 1'b1, 1'b0, "R8");
        point_check(dbl_en && att_code == 0 && !fmt_i2s, "R8", dbl_en, 1);

        // R9: serial write in parallel mode is ignored, serial state kept
        send({8'h00, 8'h33}, 8, "R9");
        chk_en = 0;
        sel_serial = 1'b1; m_serial = 1;
        wclk(5);
        cur_req = "R9";
        chk_en = 1;
        wclk(4);
        point_check(att_code == 7'h12 && fmt_i2s && deem_rate == 2'b10, "R9", att_code, 'h12);

        chk_en = 0;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule